// File: doc/BRIEF.md
# EEPROM Configuration Reload Sequencer

This block fills the station address and the two subsystem identifier registers of a device from a fixed record stored in a serial EEPROM. A reload begins when the host issues a reload command, or once after reset when the auto-load parameter is set. The sequencer does not drive the EEPROM pins. It asks a separate command engine for one byte at a time over a request/acknowledge handshake, and it steps through the record addresses in order.

The first byte of the record is a signature. If it is not A5h, the EEPROM is treated as missing or blank. The sequencer then stops at once and reports a failure. Otherwise it reads ten more bytes into a private shadow copy. After the last byte it moves that copy into the visible holding registers in a single cycle and raises the loaded flag. If the command engine reports a timeout on any read, the reload ends the same way as a signature failure.

Top module: `eep_reload_seq`

## Requirements
- R1: While rst_ni is low: busy_o, loaded_o, fail_o and rd_req_o are 0, and mac_o, ssvid_o and ssid_o are all zero.
- R2: With AUTO_LOAD=1, one reload starts by itself after reset is released, with no command.
- R3: A one-cycle pulse on reload_i while idle starts a reload. busy_o stays 1 from the cycle after the pulse until the reload ends.
- R4: Reads go to addresses REC_BASE+0 up to REC_BASE+10 in increasing order, one request at a time. rd_req_o stays high and rd_addr_o stays stable until rd_ack_i is seen. The request drops in the cycle after the acknowledge.
- R5: If the byte at offset 0 is not A5h, the reload fails after that single read. fail_o becomes 1, loaded_o becomes 0, and the holding registers keep their values.
- R6: Record layout: offsets 1..6 give mac_o low byte first (offset 1 goes to mac_o[7:0], offset 6 to mac_o[47:40]). Offsets 7 and 8 give ssvid_o as {off8,off7}. Offsets 9 and 10 give ssid_o as {off10,off9}.
- R7: mac_o, ssvid_o and ssid_o do not change while a reload is in progress. On success all three change together, in the cycle busy_o falls.
- R8: If rd_timeout_i is high together with rd_ack_i on any read, the reload fails. No further read is requested, fail_o becomes 1, loaded_o becomes 0, and the holding registers keep their values.
- R9: loaded_o becomes 1 only when a reload completes successfully. fail_o is cleared when a new reload starts. fail_o and loaded_o are never both 1.
- R10: A reload_i pulse while busy_o is 1 is ignored. The ongoing reload finishes normally, and no second reload follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | 1 | Host reload command pulse |
| rd_req_o | output | 1 | Byte read request to the command engine |
| rd_addr_o | output | ADDR_W | EEPROM byte address of the request |
| rd_ack_i | input | 1 | Read finished (one cycle) |
| rd_data_i | input | 8 | Byte read, valid with rd_ack_i |
| rd_timeout_i | input | 1 | Read timed out, valid with rd_ack_i |
| busy_o | output | 1 | Reload in progress |
| loaded_o | output | 1 | Last reload succeeded |
| fail_o | output | 1 | Last reload failed |
| mac_o | output | 48 | Station address holding register |
| ssvid_o | output | 16 | Subsystem vendor ID holding register |
| ssid_o | output | 16 | Subsystem ID holding register |

## Verification
The bench first lets the auto-load run against a blank device (FFh signature). A design that ignored the signature, or that kept requesting after it, would request an eleventh byte or raise loaded_o. Two good records with distinct byte values check the layout. A swapped byte order or a misplaced identifier shows up as a wrong mac_o, ssvid_o or ssid_o. The holding registers are sampled halfway through a reload, which catches a design that writes them byte by byte. A reload command is also injected mid-reload, which catches a design that restarts or queues a second reload. A timeout on the sixth read and a 5Ah signature must each leave the previous good values in place, clear loaded_o, and stop further requests.

// File: rtl/eep_reload_pkg.sv
package eep_reload_pkg;
  localparam logic [7:0] SIG_BYTE  = 8'hA5;
  localparam int         REC_BYTES = 11;
  localparam int         DAT_BYTES = REC_BYTES - 1;
  localparam int         IDX_W     = $clog2(REC_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_COMMIT
  } seq_state_e;
endpackage

// File: rtl/eep_rd_port.sv
module eep_rd_port #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int BASE   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              ack_i,
  output logic              done_o
);
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else if (issue_i) begin
      req_q  <= 1'b1;
      addr_q <= ADDR_W'(BASE) + ADDR_W'(idx_i);
    end else if (req_q && ack_i) begin
      req_q  <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign done_o = req_q & ack_i;
endmodule

// File: rtl/eep_rec_shadow.sv
module eep_rec_shadow #(
  parameter int N_BYTES = 10,
  parameter int IDX_W   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     sel_i,
  input  logic [7:0]           data_i,
  output logic [8*N_BYTES-1:0] rec_o
);
  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    localparam logic [IDX_W-1:0] SEL = IDX_W'(g);
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  byte_q <= '0;
      else if (we_i && sel_i == SEL) byte_q <= data_i;
    end
    assign rec_o[8*g +: 8] = byte_q;
  end
endmodule

// File: rtl/eep_reload_fsm.sv
module eep_reload_fsm
  import eep_reload_pkg::*;
#(
  parameter bit AUTO_LOAD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic             done_i,
  input  logic [7:0]       data_i,
  input  logic             tmo_i,
  output logic             busy_o,
  output logic             issue_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             sh_we_o,
  output logic [IDX_W-1:0] sh_sel_o,
  output logic             commit_o,
  output logic             start_o,
  output logic             fail_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             armed_q;
  logic             bad_rd;

  assign bad_rd = tmo_i || (idx_q == '0 && data_i != SIG_BYTE);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    issue_o  = 1'b0;
    sh_we_o  = 1'b0;
    commit_o = 1'b0;
    start_o  = 1'b0;
    fail_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_i || armed_q) begin
        start_o = 1'b1;
        idx_d   = '0;
        state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        issue_o = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: if (done_i) begin
        if (bad_rd) begin
          fail_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          sh_we_o = idx_q != '0;
          if (idx_q == LAST_IDX) begin
            state_d = ST_COMMIT;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_COMMIT: begin
        commit_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      armed_q <= AUTO_LOAD;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (start_o) armed_q <= 1'b0;
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign idx_o    = idx_q;
  assign sh_sel_o = idx_q - 1'b1;
endmodule

// File: rtl/eep_reload_seq.sv
module eep_reload_seq
  import eep_reload_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REC_BASE  = 0,
  parameter bit AUTO_LOAD = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_timeout_i,
  output logic              busy_o,
  output logic              loaded_o,
  output logic              fail_o,
  output logic [47:0]       mac_o,
  output logic [15:0]       ssvid_o,
  output logic [15:0]       ssid_o
);
  logic             issue, done, sh_we, commit, start_evt, fail_evt;
  logic [IDX_W-1:0] idx, sh_sel;
  logic [8*DAT_BYTES-1:0] rec;
  logic        loaded_q, fail_q;
  logic [47:0] mac_q;
  logic [15:0] ssvid_q, ssid_q;

  eep_reload_fsm #(.AUTO_LOAD(AUTO_LOAD)) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (reload_i),
    .done_i   (done),
    .data_i   (rd_data_i),
    .tmo_i    (rd_timeout_i),
    .busy_o   (busy_o),
    .issue_o  (issue),
    .idx_o    (idx),
    .sh_we_o  (sh_we),
    .sh_sel_o (sh_sel),
    .commit_o (commit),
    .start_o  (start_evt),
    .fail_o   (fail_evt)
  );

  eep_rd_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(REC_BASE)) i_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .idx_i   (idx),
    .req_o   (rd_req_o),
    .addr_o  (rd_addr_o),
    .ack_i   (rd_ack_i),
    .done_o  (done)
  );

  eep_rec_shadow #(.N_BYTES(DAT_BYTES), .IDX_W(IDX_W)) i_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sh_we),
    .sel_i  (sh_sel),
    .data_i (rd_data_i),
    .rec_o  (rec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      fail_q   <= 1'b0;
      mac_q    <= '0;
      ssvid_q  <= '0;
      ssid_q   <= '0;
    end else begin
      if (start_evt) fail_q <= 1'b0;
      if (fail_evt) begin
        fail_q   <= 1'b1;
        loaded_q <= 1'b0;
      end
      if (commit) begin
        loaded_q <= 1'b1;
        mac_q    <= rec[47:0];
        ssvid_q  <= rec[63:48];
        ssid_q   <= rec[79:64];
      end
    end
  end

  assign loaded_o = loaded_q;
  assign fail_o   = fail_q;
  assign mac_o    = mac_q;
  assign ssvid_o  = ssvid_q;
  assign ssid_o   = ssid_q;
endmodule

// File: rtl/eep_reload_chk.sv
module eep_reload_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              busy_o,
  input logic              loaded_o,
  input logic              fail_o,
  input logic [47:0]       mac_o,
  input logic [15:0]       ssvid_o,
  input logic [15:0]       ssid_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R4
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> !rd_req_o); // R4
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o); // R3
  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mac_o) && $stable(ssvid_o) && $stable(ssid_o)); // R7
  AST_COMMIT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mac_o) |-> $fell(busy_o) && loaded_o); // R7
  AST_LOADED_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(loaded_o && fail_o)); // R9
  AST_LOADED_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loaded_o) |-> $fell(busy_o)); // R9
endmodule

bind eep_reload_seq eep_reload_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_ack_i  (rd_ack_i),
  .busy_o    (busy_o),
  .loaded_o  (loaded_o),
  .fail_o    (fail_o),
  .mac_o     (mac_o),
  .ssvid_o   (ssvid_o),
  .ssid_o    (ssid_o)
);

// File: tb/test_eep_reload_seq.sv
module test_eep_reload_seq;
  localparam int ADDR_W = 8;
  localparam int BASE   = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reload_i = 1'b0, rd_ack_i = 1'b0, rd_timeout_i = 1'b0;
  logic [7:0] rd_data_i = '0;
  logic rd_req_o, busy_o, loaded_o, fail_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [47:0] mac_o;
  logic [15:0] ssvid_o, ssid_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  eep_reload_seq #(.ADDR_W(ADDR_W), .REC_BASE(BASE), .AUTO_LOAD(1'b1)) i_eep_reload_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(reload_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .rd_timeout_i(rd_timeout_i),
    .busy_o(busy_o), .loaded_o(loaded_o), .fail_o(fail_o),
    .mac_o(mac_o), .ssvid_o(ssvid_o), .ssid_o(ssid_o));

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic pulse_reload();
    @(negedge clk_i) reload_i = 1'b1;
    @(negedge clk_i) reload_i = 1'b0;
  endtask

  task automatic serve(input int off, input logic [7:0] d, input bit tmo);
    @(negedge clk_i);
    while (!rd_req_o) @(negedge clk_i);
    chk(rd_addr_o == ADDR_W'(BASE + off), "R4 addr", 80'(rd_addr_o), 80'(BASE + off));
    repeat (2) @(negedge clk_i);
    chk(rd_req_o && rd_addr_o == ADDR_W'(BASE + off), "R4 held", 80'(rd_req_o), 80'd1);
    rd_ack_i = 1'b1; rd_data_i = d; rd_timeout_i = tmo;
    @(posedge clk_i); #1;
    rd_ack_i = 1'b0; rd_timeout_i = 1'b0; rd_data_i = 8'h00;
    chk(!rd_req_o, "R4 drop", 80'(rd_req_o), 80'd0);
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic no_req(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (rd_req_o || busy_o) seen = 1'b1;
    end
    chk(!seen, req, 80'(seen), 80'd0);
  endtask

  task automatic chk_hold(input logic [47:0] m, input logic [15:0] sv, input logic [15:0] s, input string req);
    chk(mac_o == m, req, 80'(mac_o), 80'(m));
    chk(ssvid_o == sv && ssid_o == s, req, {48'd0, ssvid_o, ssid_o}, {48'd0, sv, s});
  endtask

  // good full reload; optional mid-reload command
  task automatic good_reload(input logic [87:0] rec, input bit mid_cmd);
    logic [47:0] m0 = mac_o;
    pulse_reload();
    chk(busy_o, "R3 busy", 80'(busy_o), 80'd1);
    for (int i = 0; i < 11; i++) begin
      serve(i, rec[8*i +: 8], 1'b0);
      if (i == 5) begin
        chk(busy_o, "R3 busy mid", 80'(busy_o), 80'd1);
        chk(mac_o == m0, "R7 no partial", 80'(mac_o), 80'(m0));
        if (mid_cmd) pulse_reload();
      end
    end
    wait_idle();
    chk(loaded_o && !fail_o, "R9 loaded", {78'd0, loaded_o, fail_o}, 80'd2);
    chk_hold(rec[55:8], rec[71:56], rec[87:72], "R6 layout");
    if (mid_cmd) no_req("R10 ignored");
  endtask

  task automatic t_reset_auto();
    #1;
    chk(!busy_o && !loaded_o && !fail_o && !rd_req_o, "R1 flags",
        {76'd0, busy_o, loaded_o, fail_o, rd_req_o}, 80'd0);
    chk_hold('0, '0, '0, "R1 hold");
    @(negedge clk_i) rst_ni = 1'b1;
    serve(0, 8'hFF, 1'b0);  // R2: auto reload, blank device
    wait_idle();
    chk(fail_o && !loaded_o, "R5 blank", {78'd0, fail_o, loaded_o}, 80'd2);
    chk_hold('0, '0, '0, "R5 hold");
    no_req("R5 stop");
  endtask

  task automatic t_bad_sig();
    logic [47:0] m = mac_o; logic [15:0] sv = ssvid_o, s = ssid_o;
    pulse_reload();
    serve(0, 8'h5A, 1'b0);
    wait_idle();
    chk(fail_o && !loaded_o, "R5 bad sig", {78'd0, fail_o, loaded_o}, 80'd2);
    chk_hold(m, sv, s, "R5 unchanged");
    no_req("R5 single read");
  endtask

  task automatic t_timeout(input logic [87:0] rec);
    logic [47:0] m = mac_o; logic [15:0] sv = ssvid_o, s = ssid_o;
    pulse_reload();
    chk(!fail_o, "R9 fail cleared", 80'(fail_o), 80'd0);
    for (int i = 0; i < 6; i++) serve(i, rec[8*i +: 8], i == 5);
    wait_idle();
    chk(fail_o && !loaded_o, "R8 timeout", {78'd0, fail_o, loaded_o}, 80'd2);
    chk_hold(m, sv, s, "R8 unchanged");
    no_req("R8 stop");
  endtask

  initial begin
    t_reset_auto();
    good_reload({8'h3C, 8'h2B, 8'h1A, 8'h09, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'hA5}, 1'b0);
    good_reload({8'hE0, 8'hD1, 8'hC2, 8'hB3, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h81, 8'hA5}, 1'b1);
    t_bad_sig();
    t_timeout({8'h00, 8'h00, 8'h00, 8'h00, 8'hFE, 8'hED, 8'hCB, 8'hA9, 8'h87, 8'h65, 8'hA5});
    good_reload({8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'h0F, 8'hF1, 8'hA5}, 1'b0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    summary();
  end
endmodule